// File: doc/BRIEF.md
# DMA Bus Master Cycle Controller

This block is the bus master engine behind an on-chip DMA unit that shares a multiplexed 16-bit address/data bus with a host. A burst queue inside the chip presents one transfer at a time: direction, byte lanes, address and write data. The controller wins the bus, runs an address phase and then a data phase for each queued transfer, and gives the bus back. The data phase ends on an asynchronous READY from memory. While it owns the bus it drives the direction line, the address strobe, the data strobe, the byte-select pins and the enables of the external bus transceiver.

Two run-time control bits change the bus protocol. `cfg_alt_bus` chooses how byte lanes are signalled: either a two-line mask, or a BYTE line combined with address bit 0. The same bit also turns on the downstream bus-grant acknowledge used in a daisy chain. `cfg_as_strobe` chooses the style of the address strobe. In latch-enable style the strobe is high for the address phase and low for the data phase. In pulse style it is the inverse: low for the address phase only. The bus tenure ends for one of three reasons: the programmed burst length has been reached, the queue is empty, or an enabled host burst-release input is asserted. In each case the current transfer completes first.

State machine: `ST_IDLE` (bus not wanted) → `ST_REQ` when the queue is non-empty and the grant is inactive. `ST_REQ` (request low, waiting) → `ST_ADDR` when the grant arrives. `ST_ADDR` (one clock, address phase) → `ST_DATA`. `ST_DATA` (data strobe low) → `ST_DONE` when synchronised READY is seen. From `ST_DONE` (data strobe high, transfer counted) the machine returns to `ST_ADDR` for the next queued transfer, or goes to `ST_REL` on burst end, empty queue or burst release. `ST_REL` (request high) → `ST_IDLE` once the grant goes inactive.

Top module: `dma_bus_master`

## Requirements
- R1: After reset: `req_n`=1, `bus_oe`=0, `das_n`=1, `busako_n`=1, `xcv_out_en`=0, `xcv_in_en`=0, `req_pop`=0, `rd_valid`=0.
- R2: `req_n` goes low one clock after the queue is non-empty while `hlda_n`=1 (synchronous to `clk`). It stays high while `hlda_n` is held low by another master. It remains low for as long as `bus_oe` is high.
- R3: When `cfg_alt_bus`=1, `busako_n` goes low one clock after `hlda_n` goes low while the block is idle and not requesting. It stays high while the block requests or owns the bus, and it is always high when `cfg_alt_bus`=0.
- R4: With `cfg_alt_bus`=0, `lane_o` = {BM1,BM0} copies the request lane code during the address phase: 00 whole word, 01 upper byte, 10 lower byte, 11 no byte. `dal_out` carries `req_addr` unchanged.
- R5: With `cfg_alt_bus`=1, `lane_o[0]` is BYTE and `lane_o[1]` is 1. During the address phase `dal_out[0]` carries the lane bit: word → BYTE 0/bit0 0, upper → 1/1, lower → 1/0, lane code 11 → 0/1.
- R6: With `cfg_as_strobe`=0, `strobe_o` is 1 in the address phase and 0 in the data phase. With `cfg_as_strobe`=1 it is 0 in the address phase and 1 in the data phase.
- R7: `xcv_out_en` is 1 in every address phase and through the data phase of a write. `xcv_in_en` is 1 only in the data phase of a read. The two are never high together, and `dal_oe` follows `xcv_out_en`. In a write data phase `dal_out` carries the write data.
- R8: `read_o` is 1 for a read and 0 for a write during the whole transaction. `bus_oe` (enable for `read_o`, `strobe_o`, `das_n`, `lane_o`) is 1 only while master, and `das_n` is low only then.
- R9: `ready_n` passes through two flops. `das_n` rises on the third rising edge after `ready_n` goes low. Read data on `dal_in` is captured into `rd_data` at that edge and flagged by a one-clock `rd_valid`.
- R10: A tenure carries at most `burst_len` transfers, with 0 treated as 1. `req_pop` pulses once per completed transfer.
- R11: A tenure ends after the transfer that empties the queue, even below `burst_len`.
- R12: With `cfg_rel_en`=1, a low `burst_rel_n` ends the tenure after the current transfer. With `cfg_rel_en`=0 it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_alt_bus | input | 1 | 0: byte-mask lanes; 1: BYTE/bit-0 lanes and daisy-chain acknowledge |
| cfg_as_strobe | input | 1 | 0: latch-enable strobe; 1: pulse strobe |
| cfg_rel_en | input | 1 | Enables the burst-release input |
| burst_len | input | CNT_W | Maximum transfers per tenure (0 acts as 1) |
| req_valid | input | 1 | Queue head valid |
| req_write | input | 1 | Queue head is a write |
| req_lane | input | 2 | Lane code of queue head |
| req_addr | input | DATA_W | Address of queue head |
| req_wdata | input | DATA_W | Write data of queue head |
| req_pop | output | 1 | Queue head transfer completed |
| rd_data | output | DATA_W | Captured read data |
| rd_valid | output | 1 | `rd_data` updated |
| hlda_n | input | 1 | Bus grant, active low |
| req_n | output | 1 | Bus request, active low |
| busako_n | output | 1 | Downstream grant acknowledge, active low |
| bus_oe | output | 1 | Master output enable for control lines |
| dal_out | output | DATA_W | Address/data bus driven value |
| dal_oe | output | 1 | Address/data bus drive enable |
| dal_in | input | DATA_W | Address/data bus sampled value |
| read_o | output | 1 | Transfer direction, 1 = read |
| strobe_o | output | 1 | Address strobe |
| das_n | output | 1 | Data strobe, active low |
| lane_o | output | 2 | Byte-select pins |
| xcv_out_en | output | 1 | Transceiver outward enable |
| xcv_in_en | output | 1 | Transceiver inward enable |
| ready_n | input | 1 | Asynchronous READY, active low |
| burst_rel_n | input | 1 | Host burst release, active low |

## Verification
The bench builds the block with DATA_W=16, CNT_W=4 and SYNC_STAGES=2. The narrow counter keeps burst limits of 0, 3, 5 and 8 within a few dozen clocks. The two-stage synchroniser makes the data-strobe edge fall on a fixed, predictable clock after READY, so the READY latency can be checked exactly. The same default widths let every lane code be exercised in both byte-select styles and both strobe styles.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_DONE,
        ST_REL
    } dmab_state_e;

    localparam logic [1:0] LANE_WORD = 2'b00;
    localparam logic [1:0] LANE_HI   = 2'b01;
    localparam logic [1:0] LANE_LO   = 2'b10;
    localparam logic [1:0] LANE_NONE = 2'b11;

endpackage

// File: rtl/dmab_sync.sv
module dmab_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= RST_VAL;
                else        sh_q <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= {STAGES{RST_VAL}};
                else        sh_q <= {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/dmab_lane_enc.sv
module dmab_lane_enc
    import dmab_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              alt,
    input  logic [1:0]        lane,
    input  logic [DATA_W-1:0] addr,
    output logic [1:0]        pins,
    output logic [DATA_W-1:0] addr_bus
);
    logic byte_sel;
    logic bit0;

    always_comb begin
        byte_sel = (lane == LANE_HI) || (lane == LANE_LO);
        bit0     = (lane == LANE_HI) || (lane == LANE_NONE);
        if (alt) begin
            pins     = {1'b1, byte_sel};
            addr_bus = {addr[DATA_W-1:1], bit0};
        end else begin
            pins     = lane;
            addr_bus = addr;
        end
    end
endmodule

// File: rtl/dmab_burst_cnt.sv
module dmab_burst_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + ONE;
    end

    always_comb begin
        limit_eff = (limit == '0) ? ONE : limit;
        hit       = (cnt_q >= limit_eff);
    end
endmodule

// File: rtl/dma_bus_master.sv
module dma_bus_master
    import dmab_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_alt_bus,
    input  logic              cfg_as_strobe,
    input  logic              cfg_rel_en,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_lane,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              hlda_n,
    output logic              req_n,
    output logic              busako_n,
    output logic              bus_oe,
    output logic [DATA_W-1:0] dal_out,
    output logic              dal_oe,
    input  logic [DATA_W-1:0] dal_in,
    output logic              read_o,
    output logic              strobe_o,
    output logic              das_n,
    output logic [1:0]        lane_o,
    output logic              xcv_out_en,
    output logic              xcv_in_en,
    input  logic              ready_n,
    input  logic              burst_rel_n
);
    dmab_state_e       state_q, state_d;
    logic              rdy_n_s, rdy_s;
    logic              hit;
    logic              rel_q, rel_now, stop;
    logic              wr_q, cur_wr;
    logic [DATA_W-1:0] wd_q;
    logic [1:0]        lane_q;
    logic [1:0]        enc_pins;
    logic [DATA_W-1:0] enc_addr;
    logic              busako_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              master;

    dmab_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_rdy_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (ready_n),
        .q    (rdy_n_s)
    );
    assign rdy_s = ~rdy_n_s;

    dmab_lane_enc #(.DATA_W(DATA_W)) i_lane_enc (
        .alt     (cfg_alt_bus),
        .lane    (req_lane),
        .addr    (req_addr),
        .pins    (enc_pins),
        .addr_bus(enc_addr)
    );

    dmab_burst_cnt #(.CNT_W(CNT_W)) i_burst_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_q == ST_REL),
        .inc  (req_pop),
        .limit(burst_len),
        .hit  (hit)
    );

    assign rel_now = cfg_rel_en & ~burst_rel_n;
    assign stop    = hit | ~req_valid | rel_q | rel_now;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid && hlda_n) state_d = ST_REQ;
            ST_REQ:  if (!hlda_n)             state_d = ST_ADDR;
            ST_ADDR:                          state_d = ST_DATA;
            ST_DATA: if (rdy_s)               state_d = ST_DONE;
            ST_DONE: state_d = stop ? ST_REL : ST_ADDR;
            ST_REL:  if (hlda_n)              state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transfer context, release latch, acknowledge, read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q       <= 1'b0;
            wd_q       <= '0;
            lane_q     <= 2'b11;
            rel_q      <= 1'b0;
            busako_q   <= 1'b1;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            if (state_q == ST_ADDR) begin
                wr_q   <= req_write;
                wd_q   <= req_wdata;
                lane_q <= enc_pins;
            end
            if (state_q == ST_REL)     rel_q <= 1'b0;
            else if (master && rel_now) rel_q <= 1'b1;
            busako_q   <= ~(cfg_alt_bus && !hlda_n && state_q == ST_IDLE);
            rd_valid_q <= (state_q == ST_DATA) && rdy_s && !wr_q;
            if ((state_q == ST_DATA) && rdy_s && !wr_q) rd_data_q <= dal_in;
        end
    end

    // outputs
    always_comb begin
        master     = 1'b0;
        req_n      = 1'b1;
        strobe_o   = cfg_as_strobe;
        das_n      = 1'b1;
        xcv_out_en = 1'b0;
        xcv_in_en  = 1'b0;
        req_pop    = 1'b0;
        cur_wr     = wr_q;
        dal_out    = wd_q;
        lane_o     = lane_q;
        unique case (state_q)
            ST_IDLE, ST_REL: ;
            ST_REQ: req_n = 1'b0;
            ST_ADDR: begin
                master     = 1'b1;
                req_n      = 1'b0;
                strobe_o   = ~cfg_as_strobe;
                xcv_out_en = 1'b1;
                cur_wr     = req_write;
                dal_out    = enc_addr;
                lane_o     = enc_pins;
            end
            ST_DATA: begin
                master     = 1'b1;
                req_n      = 1'b0;
                das_n      = 1'b0;
                xcv_out_en = wr_q;
                xcv_in_en  = ~wr_q;
                req_pop    = rdy_s;
            end
            ST_DONE: begin
                master     = 1'b1;
                req_n      = 1'b0;
                xcv_out_en = wr_q;
            end
            default: ;
        endcase
        bus_oe   = master;
        dal_oe   = xcv_out_en;
        read_o   = master & ~cur_wr;
        busako_n = busako_q;
        rd_valid = rd_valid_q;
        rd_data  = rd_data_q;
    end
endmodule

// File: rtl/dmab_checker.sv
module dmab_checker (
    input logic clk,
    input logic rst_n,
    input logic req_n,
    input logic bus_oe,
    input logic das_n,
    input logic strobe_o,
    input logic cfg_as_strobe,
    input logic xcv_in_en,
    input logic xcv_out_en,
    input logic busako_n,
    input logic req_pop,
    input logic rdy_s
);
    AST_TENURE_HELD: assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> !req_n); // R2
    AST_ACK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busako_n |-> (req_n && !bus_oe)); // R3
    AST_ALE_LOW_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n) (!das_n && !cfg_as_strobe) |-> !strobe_o); // R6
    AST_AS_HIGH_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n) (!das_n && cfg_as_strobe) |-> strobe_o); // R6
    AST_XCV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(xcv_in_en && xcv_out_en)); // R7
    AST_DAS_ONLY_MASTER: assert property (@(posedge clk) disable iff (!rst_n) !das_n |-> bus_oe); // R8
    AST_DAS_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n) $rose(das_n) |-> $past(rdy_s)); // R9
    AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n) req_pop |=> !req_pop); // R10
endmodule

bind dma_bus_master dmab_checker i_dmab_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_n        (req_n),
    .bus_oe       (bus_oe),
    .das_n        (das_n),
    .strobe_o     (strobe_o),
    .cfg_as_strobe(cfg_as_strobe),
    .xcv_in_en    (xcv_in_en),
    .xcv_out_en   (xcv_out_en),
    .busako_n     (busako_n),
    .req_pop      (req_pop),
    .rdy_s        (rdy_s)
);

// File: tb/test_dma_bus_master.sv
`timescale 1ns/1ps
module test_dma_bus_master;
    localparam int DW = 16;
    localparam int CW = 4;
    localparam logic [15:0] MEMX = 16'h5A0F;

    typedef struct packed {
        logic        alt;
        logic        as_s;
        logic        wr;
        logic [1:0]  lane;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [1:0]  xlane;
        logic [15:0] xdal;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 2'b00, 16'h1234, 16'h0000, 2'b00, 16'h1234},
        '{1'b0, 1'b1, 1'b1, 2'b01, 16'h2001, 16'hBEEF, 2'b01, 16'h2001},
        '{1'b0, 1'b0, 1'b1, 2'b10, 16'h0FF0, 16'hC0DE, 2'b10, 16'h0FF0},
        '{1'b0, 1'b1, 1'b0, 2'b11, 16'h7ABC, 16'h0000, 2'b11, 16'h7ABC},
        '{1'b1, 1'b0, 1'b0, 2'b00, 16'h3457, 16'h0000, 2'b10, 16'h3456},
        '{1'b1, 1'b1, 1'b1, 2'b01, 16'h4000, 16'h1357, 2'b11, 16'h4001},
        '{1'b1, 1'b0, 1'b1, 2'b10, 16'h5555, 16'h2468, 2'b11, 16'h5554},
        '{1'b1, 1'b1, 1'b0, 2'b11, 16'h6000, 16'h0000, 2'b10, 16'h6001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_alt_bus = 1'b0, cfg_as_strobe = 1'b0, cfg_rel_en = 1'b0;
    logic [CW-1:0] burst_len = CW'(1);
    logic          req_valid, req_write;
    logic [1:0]    req_lane;
    logic [DW-1:0] req_addr, req_wdata;
    logic          req_pop, rd_valid;
    logic [DW-1:0] rd_data;
    logic          hlda_n, req_n, busako_n, bus_oe, dal_oe, read_o, strobe_o, das_n;
    logic [DW-1:0] dal_out;
    logic [DW-1:0] dal_in = '0;
    logic [1:0]    lane_o;
    logic          xcv_out_en, xcv_in_en, ready_n;
    logic          burst_rel_n = 1'b1;

    logic arb_auto = 1'b1, mem_auto = 1'b1;
    logic man_hlda_n = 1'b1, man_ready_n = 1'b1;
    logic auto_hlda_n = 1'b1, auto_ready_n = 1'b1;
    assign hlda_n  = arb_auto ? auto_hlda_n : man_hlda_n;
    assign ready_n = mem_auto ? auto_ready_n : man_ready_n;

    // request queue
    logic          q_wr [64];
    logic [1:0]    q_lane [64];
    logic [15:0]   q_addr [64];
    logic [15:0]   q_wd [64];
    int            q_tail = 0;
    int            pop_cnt = 0;
    assign req_valid = pop_cnt < q_tail;
    assign req_write = q_wr[pop_cnt[5:0]];
    assign req_lane  = q_lane[pop_cnt[5:0]];
    assign req_addr  = q_addr[pop_cnt[5:0]];
    assign req_wdata = q_wd[pop_cnt[5:0]];
    always @(posedge clk) if (req_pop) pop_cnt <= pop_cnt + 1;

    dma_bus_master #(.DATA_W(DW), .CNT_W(CW), .SYNC_STAGES(2)) i_dma_bus_master (
        .clk(clk), .rst_n(rst_n), .cfg_alt_bus(cfg_alt_bus), .cfg_as_strobe(cfg_as_strobe),
        .cfg_rel_en(cfg_rel_en), .burst_len(burst_len), .req_valid(req_valid),
        .req_write(req_write), .req_lane(req_lane), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_pop(req_pop), .rd_data(rd_data), .rd_valid(rd_valid), .hlda_n(hlda_n),
        .req_n(req_n), .busako_n(busako_n), .bus_oe(bus_oe), .dal_out(dal_out),
        .dal_oe(dal_oe), .dal_in(dal_in), .read_o(read_o), .strobe_o(strobe_o),
        .das_n(das_n), .lane_o(lane_o), .xcv_out_en(xcv_out_en), .xcv_in_en(xcv_in_en),
        .ready_n(ready_n), .burst_rel_n(burst_rel_n)
    );

    always #10 clk = ~clk;

    // monitor and bus responders, all at the falling edge
    logic [15:0] a_dal [64];
    logic [1:0]  a_lane [64];
    logic        a_read [64], a_xo [64], a_xi [64];
    logic [15:0] d_dal [64];
    logic        d_oe [64], d_xo [64], d_xi [64], d_strb [64];
    logic [15:0] r_dat [64];
    int          ten [64];
    int          na = 0, nd = 0, nr = 0, nt = 0, tpop = 0;
    logic        prev_das_n = 1'b1, prev_req_n = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_oe && das_n && (strobe_o == !cfg_as_strobe)) begin
                a_dal[na[5:0]] = dal_out;  a_lane[na[5:0]] = lane_o;
                a_read[na[5:0]] = read_o;  a_xo[na[5:0]] = xcv_out_en;
                a_xi[na[5:0]] = xcv_in_en;
                dal_in = dal_out ^ MEMX;
                na++;
            end
            if (!das_n && prev_das_n) begin
                d_dal[nd[5:0]] = dal_out; d_oe[nd[5:0]] = dal_oe;
                d_xo[nd[5:0]] = xcv_out_en; d_xi[nd[5:0]] = xcv_in_en;
                d_strb[nd[5:0]] = strobe_o;
                nd++;
            end
            if (rd_valid) begin r_dat[nr[5:0]] = rd_data; nr++; end
            if (req_pop) tpop++;
            if (req_n && !prev_req_n) begin ten[nt[5:0]] = tpop; nt++; tpop = 0; end
        end
        prev_das_n   = das_n;
        prev_req_n   = req_n;
        auto_hlda_n  = req_n;
        auto_ready_n = das_n;
    end

    int n_chk = 0, n_bad = 0;
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic wr, input logic [1:0] ln, input logic [15:0] ad, input logic [15:0] wd);
        q_wr[q_tail[5:0]] = wr; q_lane[q_tail[5:0]] = ln;
        q_addr[q_tail[5:0]] = ad; q_wd[q_tail[5:0]] = wd;
        q_tail++;
    endtask

    task automatic wait_ten(input int target);
        while (nt < target) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 req_n", req_n, 1); chk("R1 bus_oe", bus_oe, 0); chk("R1 das_n", das_n, 1);
        chk("R1 busako_n", busako_n, 1); chk("R1 xcv", {xcv_out_en, xcv_in_en}, 0);
        chk("R1 pop/rdv", {req_pop, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle req_n", req_n, 1);

        // vector table: one single-transfer tenure each
        for (int v = 0; v < NV; v++) begin
            int ba, bd, br, bt;
            ba = na; bd = nd; br = nr; bt = nt;
            cfg_alt_bus = VECS[v].alt; cfg_as_strobe = VECS[v].as_s; burst_len = CW'(1);
            push(VECS[v].wr, VECS[v].lane, VECS[v].addr, VECS[v].wdata);
            wait_ten(bt + 1);
            chk($sformatf("R4 R5 lane v%0d", v), a_lane[ba[5:0]], VECS[v].xlane);
            chk($sformatf("R4 R5 addr v%0d", v), a_dal[ba[5:0]], VECS[v].xdal);
            chk($sformatf("R8 read_o v%0d", v), a_read[ba[5:0]], !VECS[v].wr);
            chk($sformatf("R7 addr xcv v%0d", v), {a_xo[ba[5:0]], a_xi[ba[5:0]]}, 2'b10);
            chk($sformatf("R6 data strobe v%0d", v), d_strb[bd[5:0]], VECS[v].as_s);
            if (VECS[v].wr) begin
                chk($sformatf("R7 wr xcv v%0d", v), {d_xo[bd[5:0]], d_xi[bd[5:0]], d_oe[bd[5:0]]}, 3'b101);
                chk($sformatf("R7 wdata v%0d", v), d_dal[bd[5:0]], VECS[v].wdata);
            end else begin
                chk($sformatf("R7 rd xcv v%0d", v), {d_xo[bd[5:0]], d_xi[bd[5:0]], d_oe[bd[5:0]]}, 3'b010);
                chk($sformatf("R9 rdata v%0d", v), r_dat[br[5:0]], VECS[v].xdal ^ MEMX);
            end
        end
        cfg_alt_bus = 1'b0; cfg_as_strobe = 1'b0;

        // R9 READY latency
        mem_auto = 1'b0; man_ready_n = 1'b1;
        b = nt;
        push(1'b0, 2'b00, 16'h0100, 16'h0);
        do @(negedge clk); while (das_n);
        man_ready_n = 1'b0;
        @(negedge clk); chk("R9 das after 1 edge", das_n, 0);
        @(negedge clk); chk("R9 das after 2 edges", das_n, 0);
        @(negedge clk); chk("R9 das after 3 edges", das_n, 1);
        man_ready_n = 1'b1;
        wait_ten(b + 1);
        mem_auto = 1'b1;

        // R10 burst length 3 over 5 transfers, then length 0
        b = nt; burst_len = CW'(3);
        for (int i = 0; i < 5; i++) push(1'b1, 2'b00, 16'h0200 + 16'(i), 16'h1111 * 16'(i));
        wait_ten(b + 2);
        chk("R10 first tenure", ten[b[5:0]], 3); chk("R10 second tenure", ten[(b+1)&63], 2);
        b = nt; burst_len = CW'(0);
        push(1'b1, 2'b00, 16'h0300, 16'h1); push(1'b1, 2'b00, 16'h0302, 16'h2);
        wait_ten(b + 2);
        chk("R10 len0 tenure a", ten[b[5:0]], 1); chk("R10 len0 tenure b", ten[(b+1)&63], 1);

        // R11 queue empties below burst length
        b = nt; burst_len = CW'(5);
        push(1'b0, 2'b00, 16'h0400, 16'h0); push(1'b1, 2'b10, 16'h0402, 16'h5);
        wait_ten(b + 1);
        repeat (6) @(negedge clk);
        chk("R11 tenure size", ten[b[5:0]], 2); chk("R11 one tenure", nt - b, 1);

        // R12 burst release enabled then disabled
        b = nt; burst_len = CW'(8); cfg_rel_en = 1'b1; burst_rel_n = 1'b0;
        for (int i = 0; i < 4; i++) push(1'b1, 2'b00, 16'h0500 + 16'(2*i), 16'h0);
        while (nt < b + 1) @(negedge clk);
        @(negedge clk); burst_rel_n = 1'b1;
        wait_ten(b + 2);
        chk("R12 released after one", ten[b[5:0]], 1); chk("R12 rest", ten[(b+1)&63], 3);
        b = nt; cfg_rel_en = 1'b0; burst_rel_n = 1'b0;
        for (int i = 0; i < 3; i++) push(1'b0, 2'b00, 16'h0600 + 16'(2*i), 16'h0);
        wait_ten(b + 1);
        chk("R12 release ignored", ten[b[5:0]], 3);
        burst_rel_n = 1'b1;

        // R2 R3 arbitration and daisy-chain acknowledge
        arb_auto = 1'b0; man_hlda_n = 1'b1; cfg_alt_bus = 1'b1; burst_len = CW'(1);
        @(negedge clk); man_hlda_n = 1'b0;
        @(negedge clk); chk("R3 busako low when idle", busako_n, 0);
        b = nt;
        push(1'b1, 2'b00, 16'h0700, 16'h7);
        @(negedge clk); @(negedge clk);
        chk("R2 no request under foreign grant", req_n, 1);
        man_hlda_n = 1'b1;
        @(negedge clk); chk("R2 request raised", req_n, 0); chk("R3 busako high", busako_n, 1);
        man_hlda_n = 1'b0;
        @(negedge clk); chk("R3 busako while master", busako_n, 1); chk("R8 bus_oe master", bus_oe, 1);
        arb_auto = 1'b1;
        wait_ten(b + 1);
        arb_auto = 1'b0; man_hlda_n = 1'b0; cfg_alt_bus = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R3 busako mask mode", busako_n, 1);
        man_hlda_n = 1'b1; arb_auto = 1'b1;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule